// File: doc/BRIEF.md
# IP Header Exception Classifier

This block watches a packet one byte per cycle, starting at the first byte of the layer-3 header, and reports one 3-bit exception code for each packet. The link layer supplies a type hint together with the first byte: 0x0800 announces IPv4 and 0x86DD announces IPv6. Any other value marks the packet as non-IP. Bytes are presented with a valid strobe, and the last byte of the packet carries an end marker. The block counts the bytes it receives itself. From that count and the header fields it captures, it decides whether the header is well formed.

The verdict appears for one cycle, the cycle after the end-marked byte is accepted. Several conditions can hold at once, so the block reports the lowest-numbered code that applies, and 0 when none applies. A new packet may begin in the same cycle that the previous verdict is shown. Later downstream stages use the code to steer or drop traffic. Fragments, transport-layer headers and forwarding are not examined.

Top module: `ipx_classifier`

## Requirements
- R1: While reset is asserted and in the cycles after it, `exc_vld` is 0. A packet cut short by reset produces no verdict, and the next packet is classified on its own bytes.
- R2: Each packet produces exactly one `exc_vld` pulse, in the cycle after the byte with `byte_eop` set is accepted. Cycles with `byte_vld` low are not counted as received bytes.
- R3: Code 1 is reported when the hint is neither 0x0800 nor 0x86DD. It is also reported when the high nibble of byte 0 is not 4 under the IPv4 hint, or not 6 under the IPv6 hint.
- R4: Code 2 is reported for IPv4 when the ones'-complement sum of the big-endian 16-bit words over the first IHL*4 bytes is not 0xFFFF. IHL is the low nibble of byte 0. The checksum is judged only when the whole header was received.
- R5: Code 3 is reported when the received bytes do not cover the header. For IPv4 this means IHL < 5 or fewer than IHL*4 bytes. For IPv6 it means fewer than 40 bytes.
- R6: Code 4 is reported when fewer bytes arrive than the header declares. For IPv4 the declared length is the total length in bytes 2–3. For IPv6 it is 40 plus the payload length in bytes 4–5. Bytes beyond the declared length cause no exception.
- R7: Code 5 is reported when the IPv4 TTL (byte 8) or the IPv6 hop limit (byte 7) is zero.
- R8: Code 6 is reported when IPv4 has IHL > 5, or when the IPv6 next-header byte (byte 6) is 0, 43 or 60. Other next-header values, such as 44, are not flagged.
- R9: When several conditions hold, the lowest nonzero code is reported. Code 0 is reported when none holds.
- R10: The type hint is sampled only with the first byte of a packet. A packet may start in the cycle its predecessor's verdict is shown, without disturbing that verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A byte is presented this cycle |
| byte_data | input | 8 | Packet byte, layer-3 header first |
| byte_eop | input | 1 | Marks the last byte of the packet |
| l2_type | input | 16 | Link-layer type hint, taken with the first byte |
| exc_vld | output | 1 | One-cycle verdict strobe |
| exc_code | output | 3 | Exception code, valid with `exc_vld` |

## Verification
The hardest cases to reach from the ports are those where several exceptions overlap. Examples are a truncated IPv4 header whose checksum bytes are wrong, a bad checksum together with a zero TTL, and a short IPv6 packet that also carries an extension header. In each of these only the ordering rule decides the code. The bench builds every header with a correct checksum and then deliberately corrupts, truncates or pads it. It also sends packets with idle cycles between bytes and packets chained with no idle cycle between them. These show that the count ignores idle cycles and that the hint is taken only from the first byte.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

    typedef enum logic [1:0] {
        L3_NONE = 2'd0,
        L3_V4   = 2'd1,
        L3_V6   = 2'd2
    } l3_kind_e;

    typedef enum logic [2:0] {
        EXC_NONE       = 3'd0,
        EXC_NOT_IP     = 3'd1,
        EXC_HDR_CSUM   = 3'd2,
        EXC_HDR_SHORT  = 3'd3,
        EXC_BODY_SHORT = 3'd4,
        EXC_TTL_ZERO   = 3'd5,
        EXC_OPTIONS    = 3'd6
    } exc_code_e;

    localparam logic [15:0] HINT_V4 = 16'h0800;
    localparam logic [15:0] HINT_V6 = 16'h86DD;

    localparam logic [7:0] NH_HOP_BY_HOP = 8'd0;
    localparam logic [7:0] NH_ROUTING    = 8'd43;
    localparam logic [7:0] NH_DEST_OPTS  = 8'd60;

    localparam int unsigned V6_HDR_BYTES = 40;
    localparam int unsigned V4_MIN_IHL   = 5;

endpackage

// File: rtl/ipx_hdr_capture.sv
module ipx_hdr_capture
    import ipx_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             byte_eop,
    input  logic [15:0]      l2_type,
    output logic             first,
    output logic [CNT_W-1:0] idx,
    output logic [CNT_W-1:0] cnt,
    output logic             done,
    output l3_kind_e         kind,
    output logic [3:0]       ver,
    output logic [3:0]       ihl,
    output logic [15:0]      w23,
    output logic [15:0]      w45,
    output logic [7:0]       b6,
    output logic [7:0]       b7,
    output logic [7:0]       b8
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             in_pkt;
        logic             done;
        logic [CNT_W-1:0] cnt;
        l3_kind_e         kind;
        logic [3:0]       ver;
        logic [3:0]       ihl;
        logic [15:0]      w23;
        logic [15:0]      w45;
        logic [7:0]       b6;
        logic [7:0]       b7;
        logic [7:0]       b8;
    } cap_t;

    cap_t cap_d, cap_q;

    function automatic l3_kind_e decode_hint(input logic [15:0] t);
        if (t == HINT_V4)      return L3_V4;
        else if (t == HINT_V6) return L3_V6;
        else                   return L3_NONE;
    endfunction

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = 1'b0;
        first      = byte_vld && !cap_q.in_pkt;
        idx        = first ? '0 : cap_q.cnt;
        if (byte_vld) begin
            if (first) begin
                cap_d.kind = decode_hint(l2_type);
                cap_d.ver  = '0;
                cap_d.ihl  = '0;
                cap_d.w23  = '0;
                cap_d.w45  = '0;
                cap_d.b6   = '0;
                cap_d.b7   = '0;
                cap_d.b8   = '0;
            end
            cap_d.cnt = (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);
            case (idx)
                CNT_W'(0): begin
                    cap_d.ver = byte_data[7:4];
                    cap_d.ihl = byte_data[3:0];
                end
                CNT_W'(2): cap_d.w23[15:8] = byte_data;
                CNT_W'(3): cap_d.w23[7:0]  = byte_data;
                CNT_W'(4): cap_d.w45[15:8] = byte_data;
                CNT_W'(5): cap_d.w45[7:0]  = byte_data;
                CNT_W'(6): cap_d.b6        = byte_data;
                CNT_W'(7): cap_d.b7        = byte_data;
                CNT_W'(8): cap_d.b8        = byte_data;
                default: ;
            endcase
            cap_d.in_pkt = !byte_eop;
            cap_d.done   = byte_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cnt  = cap_q.cnt;
    assign done = cap_q.done;
    assign kind = cap_q.kind;
    assign ver  = cap_q.ver;
    assign ihl  = cap_q.ihl;
    assign w23  = cap_q.w23;
    assign w45  = cap_q.w45;
    assign b6   = cap_q.b6;
    assign b7   = cap_q.b7;
    assign b8   = cap_q.b8;

    // R2: each further byte of a packet advances the count by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && cap_q.in_pkt && cap_q.cnt != CNT_MAX)
            |=> (cap_q.cnt == $past(cap_q.cnt) + CNT_W'(1)));

    // R2: idle cycles leave the count untouched
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(cap_q.cnt));

endmodule

// File: rtl/ipx_csum.sv
module ipx_csum #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             first,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       byte_data,
    input  logic [3:0]       ihl,
    output logic             sum_ok
);

    typedef struct packed {
        logic [15:0] sum;
        logic [7:0]  hi;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [16:0]      wide;
    logic [CNT_W-1:0] hdr_lim;

    always_comb begin
        acc_d   = acc_q;
        hdr_lim = CNT_W'({ihl, 2'b00});
        wide    = {1'b0, acc_q.sum} + {1'b0, acc_q.hi, byte_data};
        if (byte_vld) begin
            if (first) begin
                acc_d.sum = '0;
                acc_d.hi  = byte_data;
            end else if (!idx[0]) begin
                acc_d.hi = byte_data;
            end else if (idx < hdr_lim) begin
                acc_d.sum = wide[15:0] + {15'b0, wide[16]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum_ok = (acc_q.sum == 16'hFFFF);

    // R4: the accumulator restarts with every new packet
    a_r4_sum_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && first) |=> (acc_q.sum == 16'h0000));

endmodule

// File: rtl/ipx_verdict.sv
module ipx_verdict
    import ipx_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  l3_kind_e         kind,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       ver,
    input  logic [3:0]       ihl,
    input  logic [15:0]      w23,
    input  logic [15:0]      w45,
    input  logic [7:0]       b6,
    input  logic [7:0]       b7,
    input  logic [7:0]       b8,
    input  logic             sum_ok,
    output exc_code_e        code
);

    localparam int unsigned CMP_W = (CNT_W > 17) ? CNT_W : 17;

    logic [CMP_W-1:0] rx, v4_hdr, v4_need, v6_need;
    logic             v4_hdr_ok, v6_ext;

    always_comb begin
        rx        = CMP_W'(cnt);
        v4_hdr    = CMP_W'({ihl, 2'b00});
        v4_need   = CMP_W'(w23);
        v6_need   = CMP_W'(w45) + CMP_W'(V6_HDR_BYTES);
        v4_hdr_ok = (ihl >= 4'(V4_MIN_IHL)) && (rx >= v4_hdr);
        v6_ext    = (b6 == NH_HOP_BY_HOP) || (b6 == NH_ROUTING) || (b6 == NH_DEST_OPTS);
        code      = EXC_NOT_IP;
        case (kind)
            L3_V4: begin
                if (ver != 4'd4)                    code = EXC_NOT_IP;
                else if (v4_hdr_ok && !sum_ok)      code = EXC_HDR_CSUM;
                else if (!v4_hdr_ok)                code = EXC_HDR_SHORT;
                else if (rx < v4_need)              code = EXC_BODY_SHORT;
                else if (b8 == 8'd0)                code = EXC_TTL_ZERO;
                else if (ihl > 4'(V4_MIN_IHL))      code = EXC_OPTIONS;
                else                                code = EXC_NONE;
            end
            L3_V6: begin
                if (ver != 4'd6)                    code = EXC_NOT_IP;
                else if (rx < CMP_W'(V6_HDR_BYTES)) code = EXC_HDR_SHORT;
                else if (rx < v6_need)              code = EXC_BODY_SHORT;
                else if (b7 == 8'd0)                code = EXC_TTL_ZERO;
                else if (v6_ext)                    code = EXC_OPTIONS;
                else                                code = EXC_NONE;
            end
            default: code = EXC_NOT_IP;
        endcase
    end

endmodule

// File: rtl/ipx_classifier.sv
module ipx_classifier
    import ipx_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        byte_eop,
    input  logic [15:0] l2_type,
    output logic        exc_vld,
    output logic [2:0]  exc_code
);

    logic             first, done, sum_ok;
    logic [CNT_W-1:0] idx, cnt;
    l3_kind_e         kind;
    logic [3:0]       ver, ihl;
    logic [15:0]      w23, w45;
    logic [7:0]       b6, b7, b8;
    exc_code_e        code;

    ipx_hdr_capture #(.CNT_W(CNT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_eop  (byte_eop),
        .l2_type   (l2_type),
        .first     (first),
        .idx       (idx),
        .cnt       (cnt),
        .done      (done),
        .kind      (kind),
        .ver       (ver),
        .ihl       (ihl),
        .w23       (w23),
        .w45       (w45),
        .b6        (b6),
        .b7        (b7),
        .b8        (b8)
    );

    ipx_csum #(.CNT_W(CNT_W)) u_csum (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .first     (first),
        .idx       (idx),
        .byte_data (byte_data),
        .ihl       (ihl),
        .sum_ok    (sum_ok)
    );

    ipx_verdict #(.CNT_W(CNT_W)) u_verdict (
        .kind   (kind),
        .cnt    (cnt),
        .ver    (ver),
        .ihl    (ihl),
        .w23    (w23),
        .w45    (w45),
        .b6     (b6),
        .b7     (b7),
        .b8     (b8),
        .sum_ok (sum_ok),
        .code   (code)
    );

    assign exc_vld  = done;
    assign exc_code = code;

    // R2: an accepted end byte is followed by a verdict
    a_r2_verdict_follows_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_eop) |=> exc_vld);

    // R2: no verdict without an end byte in the cycle before
    a_r2_verdict_needs_eop: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vld |-> $past(byte_vld && byte_eop));

    // R9: only defined codes leave the block
    a_r9_code_defined: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vld |-> (exc_code <= 3'd6));

    // R3: a one-byte packet with a non-IP hint reports code 1
    a_r3_hint_not_ip: assert property (@(posedge clk) disable iff (!rst_n)
        (first && byte_eop && l2_type != HINT_V4 && l2_type != HINT_V6)
            |=> (exc_code == 3'd1));

endmodule

// File: tb/test_ipx_classifier.sv
`timescale 1ns/1ps
module test_ipx_classifier;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic        byte_eop;
    logic [15:0] l2_type;
    logic        exc_vld;
    logic [2:0]  exc_code;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ipx_classifier i_ipx_classifier (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_eop  (byte_eop),
        .l2_type   (l2_type),
        .exc_vld   (exc_vld),
        .exc_code  (exc_code)
    );

    typedef struct packed {
        logic        v6;
        logic [15:0] hint;
        logic [3:0]  ver;
        logic [3:0]  ihl;
        logic [15:0] lenf;
        logic [7:0]  ttl;
        logic [7:0]  nxt;
        logic [7:0]  nsend;
        logic        bad;
        logic [2:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd40, 1'b0, 3'd0, 4'd9}, // R9 clean v4
        '{1'b0, 16'h0806, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd40, 1'b0, 3'd1, 4'd3}, // R3 foreign hint
        '{1'b0, 16'h0800, 4'd6, 4'd5, 16'd40, 8'd64, 8'd0,  8'd40, 1'b0, 3'd1, 4'd3}, // R3 wrong version
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd40, 1'b1, 3'd2, 4'd4}, // R4 bad checksum
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd0,  8'd0,  8'd40, 1'b1, 3'd2, 4'd9}, // R9 csum over ttl
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd12, 1'b1, 3'd3, 4'd4}, // R4 csum not judged when cut
        '{1'b0, 16'h0800, 4'd4, 4'd4, 16'd40, 8'd64, 8'd0,  8'd40, 1'b0, 3'd3, 4'd5}, // R5 ihl below 5
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd60, 8'd64, 8'd0,  8'd50, 1'b0, 3'd4, 4'd6}, // R6 body short
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd0,  8'd0,  8'd40, 1'b0, 3'd5, 4'd7}, // R7 ttl zero
        '{1'b0, 16'h0800, 4'd4, 4'd6, 16'd44, 8'd64, 8'd0,  8'd44, 1'b0, 3'd6, 4'd8}, // R8 v4 options
        '{1'b0, 16'h0800, 4'd4, 4'd6, 16'd44, 8'd0,  8'd0,  8'd44, 1'b0, 3'd5, 4'd9}, // R9 ttl over options
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd46, 1'b0, 3'd0, 4'd6}, // R6 padding allowed
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd20, 8'd64, 8'd0,  8'd20, 1'b0, 3'd0, 4'd5}, // R5 exact header
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd20, 8'd64, 8'd0,  8'd19, 1'b0, 3'd3, 4'd5}, // R5 one byte short
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd60, 8'd0,  8'd0,  8'd50, 1'b0, 3'd4, 4'd9}, // R9 short over ttl
        '{1'b0, 16'h0800, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd1,  1'b0, 3'd3, 4'd5}, // R5 single byte
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd64, 8'd6,  8'd60, 1'b0, 3'd0, 4'd9}, // R9 clean v6
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd64, 8'd6,  8'd30, 1'b0, 3'd3, 4'd5}, // R5 v6 short header
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd30, 8'd64, 8'd6,  8'd60, 1'b0, 3'd4, 4'd6}, // R6 v6 body short
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd0,  8'd6,  8'd60, 1'b0, 3'd5, 4'd7}, // R7 hop limit zero
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd64, 8'd0,  8'd60, 1'b0, 3'd6, 4'd8}, // R8 hop-by-hop
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd64, 8'd43, 8'd60, 1'b0, 3'd6, 4'd8}, // R8 routing
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd64, 8'd60, 8'd60, 1'b0, 3'd6, 4'd8}, // R8 destination
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd64, 8'd44, 8'd60, 1'b0, 3'd0, 4'd8}, // R8 fragment not flagged
        '{1'b1, 16'h86DD, 4'd4, 4'd0, 16'd20, 8'd64, 8'd6,  8'd60, 1'b0, 3'd1, 4'd3}, // R3 v6 hint, ver 4
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd0,  8'd64, 8'd6,  8'd40, 1'b0, 3'd0, 4'd6}, // R6 exact v6 length
        '{1'b0, 16'h86DD, 4'd4, 4'd5, 16'd40, 8'd64, 8'd0,  8'd40, 1'b0, 3'd1, 4'd3}, // R3 v4 bytes, v6 hint
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd20, 8'd0,  8'd0,  8'd30, 1'b0, 3'd3, 4'd9}, // R9 short over hop/ext
        '{1'b1, 16'h86DD, 4'd6, 4'd0, 16'd40, 8'd0,  8'd43, 8'd50, 1'b0, 3'd4, 4'd9}, // R9 body over hop/ext
        '{1'b1, 16'h0801, 4'd6, 4'd0, 16'd20, 8'd64, 8'd6,  8'd60, 1'b0, 3'd1, 4'd3}  // R3 near-miss hint
    };

    logic [7:0] pkt [0:127];
    logic       pend;
    logic [2:0] pend_exp;
    logic [3:0] pend_req;

    task automatic check(input logic ok, input logic [3:0] req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build(input vec_t v);
        int s;
        int hlen;
        logic [15:0] cks;
        for (int i = 0; i < 128; i++) pkt[i] = 8'(i * 7 + 3);
        if (!v.v6) begin
            pkt[0] = {v.ver, v.ihl};
            pkt[1] = 8'h00;
            pkt[2] = v.lenf[15:8];
            pkt[3] = v.lenf[7:0];
            for (int i = 4; i < 8; i++) pkt[i] = 8'h00;
            pkt[8]  = v.ttl;
            pkt[9]  = 8'd17;
            pkt[10] = 8'h00;
            pkt[11] = 8'h00;
            hlen = int'(v.ihl) * 4;
            for (int i = 20; i < hlen; i++) pkt[i] = 8'h00;
            s = 0;
            for (int k = 0; k < hlen; k += 2) s += int'({pkt[k], pkt[k+1]});
            while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
            cks = ~16'(s);
            pkt[10] = cks[15:8];
            pkt[11] = v.bad ? (cks[7:0] ^ 8'h01) : cks[7:0];
        end else begin
            pkt[0] = {v.ver, 4'h0};
            pkt[1] = 8'h00;
            pkt[2] = 8'h00;
            pkt[3] = 8'h00;
            pkt[4] = v.lenf[15:8];
            pkt[5] = v.lenf[7:0];
            pkt[6] = v.nxt;
            pkt[7] = v.ttl;
        end
    endtask

    task automatic settle_check();
        check(exc_vld == 1'b1, pend_req, "verdict strobe", int'(exc_vld), 1);
        check(exc_code == pend_exp, pend_req, "exception code", int'(exc_code), int'(pend_exp));
        pend = 1'b0;
    endtask

    task automatic send(input vec_t v, input logic gap, input logic chain);
        logic stray;
        int   n;
        stray = 1'b0;
        n = int'(v.nsend);
        build(v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0 && pend) settle_check();
            else if (i > 0 && exc_vld) stray = 1'b1;
            byte_vld  = 1'b1;
            byte_data = pkt[i];
            byte_eop  = (i == n - 1);
            l2_type   = (i == 0) ? v.hint : ((v.hint == 16'h0800) ? 16'h86DD : 16'h0800);
            if (gap && i != n - 1) begin
                @(negedge clk);
                if (exc_vld) stray = 1'b1;
                byte_vld  = 1'b0;
                byte_data = 8'hA5;
                byte_eop  = 1'b1;
            end
        end
        // R2: no strobe while the packet is still arriving
        check(!stray, 4'd2, "strobe inside packet", int'(stray), 0);
        pend     = 1'b1;
        pend_exp = v.exp;
        pend_req = v.req;
        if (!chain) begin
            @(negedge clk);
            byte_vld = 1'b0;
            byte_eop = 1'b0;
            settle_check();
            @(negedge clk);
            // R2: the strobe lasts one cycle
            check(exc_vld == 1'b0, 4'd2, "strobe width", int'(exc_vld), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        pend      = 1'b0;
        pend_exp  = 3'd0;
        pend_req  = 4'd0;
        rst_n     = 1'b0;
        byte_vld  = 1'b0;
        byte_data = 8'h00;
        byte_eop  = 1'b0;
        l2_type   = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: idle during reset
        check(exc_vld == 1'b0, 4'd1, "strobe in reset", int'(exc_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(exc_vld == 1'b0, 4'd1, "strobe after reset", int'(exc_vld), 0);

        for (int t = 0; t < NV; t++) send(VECS[t], 1'b0, 1'b0);

        // R2: idle cycles between bytes are not counted
        send(VECS[0], 1'b1, 1'b0);
        send(VECS[7], 1'b1, 1'b0);
        send(VECS[18], 1'b1, 1'b0);

        // R10: packets chained with no idle cycle, hint taken on first byte only
        send(VECS[3], 1'b0, 1'b1);
        send(VECS[16], 1'b0, 1'b1);
        send(VECS[15], 1'b0, 1'b1);
        send(VECS[1], 1'b0, 1'b1);
        send(VECS[24], 1'b0, 1'b0);

        // R1: reset in the middle of a packet
        build(VECS[7]);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            byte_vld  = 1'b1;
            byte_data = pkt[i];
            byte_eop  = 1'b0;
            l2_type   = 16'h0800;
        end
        @(negedge clk);
        byte_vld = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(exc_vld == 1'b0, 4'd1, "no strobe for cut packet", int'(exc_vld), 0);
        send(VECS[0], 1'b0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule